// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates one virtual address at a time by walking a radix page table held in memory. A request carries the virtual address, the kind of access (instruction fetch, data load or data store), the effective privilege mode, and two status flags: one that lets supervisor code touch user pages, and one that makes execute-only pages readable by loads. The root table base and the number of translation levels are configuration inputs. The walker reads one 4-byte table entry per level through a single-beat request/response memory port. It never writes an entry back.

Each walk ends with a one-cycle result. The result is either a physical address or a fault code. A fault is a page fault that matches the access kind, or an access fault when the memory port reports that an entry address is not legal memory. A leaf found above the last level maps a superpage. The walker builds its physical page by merging the leaf's page number with the virtual page bits below that level. With zero levels configured, the walker passes the address through without reading memory.

Top module: `pt_walker`

## Requirements
- R1: With `cfg_levels` = 0 the result is the virtual address zero-extended to the physical width, with fault code 0 and no memory read.
- R2: With L levels, virtual address bits 31 down to 11+10·L must all be equal. Otherwise the walk ends with a page fault of the access kind and no memory read.
- R3: The first read targets `cfg_root_base` plus 4 times the index. At level i the index is virtual address bits [12+10·i +: 10]. The walk starts at level L-1, and the address of each later read uses the base set by the previous pointer.
- R4: A read answered with `mem_resp_err` ends the walk with fault code 4 (access fault).
- R5: An entry with V (bit 0) set and R, W and X (bits 1, 2, 3) all clear is a pointer. Its page number (bits 31:10) shifted left by 12 becomes the next base, and the walk descends one level. A pointer at level 0 is a page fault.
- R6: A leaf with U (bit 4) set faults in supervisor mode (`req_priv` = 1) when `req_sum` is 0. A leaf with U clear faults in every mode other than supervisor.
- R7: A leaf with V clear, or with W set and R clear, faults.
- R8: Access kinds are coded fetch = 0, load = 1, store = 2. A fetch needs X. A load needs R, or X while `req_mxr` is 1. A store needs both R and W.
- R9: A leaf found at level 1 faults when the low 10 bits of its page number are not zero.
- R10: A leaf faults when A (bit 6) is clear. A store also faults when D (bit 7) is clear.
- R11: A successful walk returns the page number {leaf page number OR (virtual page number masked to the 10·i bits below leaf level i)} followed by the 12 page-offset bits of the virtual address.
- R12: Fault codes are 0 none, 1 fetch page fault, 2 load page fault, 3 store page fault, 4 access fault. A faulting result carries `done_paddr` = 0.
- R13: `req_ready` is high only while idle. `mem_req_valid` is a one-cycle pulse per read, and `done_valid` is a one-cycle pulse.
- R14: After reset the walker is idle: `req_ready` = 1, `mem_req_valid` = 0, `done_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Effective mode: 0 user, 1 supervisor, 3 machine |
| req_sum | input | 1 | Supervisor may use user pages |
| req_mxr | input | 1 | Loads may read execute-only pages |
| cfg_levels | input | 2 | Number of translation levels (0 to 2) |
| cfg_root_base | input | 34 | Physical base of the root table |
| mem_req_valid | output | 1 | Entry read request, one cycle |
| mem_req_addr | output | 34 | Entry physical address |
| mem_resp_valid | input | 1 | Entry read response |
| mem_resp_data | input | 32 | Entry value |
| mem_resp_err | input | 1 | Entry address is not legal memory |
| done_valid | output | 1 | Result valid, one cycle |
| done_paddr | output | 34 | Physical address (0 on fault) |
| done_fault | output | 3 | Fault code |

## Verification
A request is taken on the edge where `req_valid` meets `req_ready`. A walk that needs no read (bare mode or a non-canonical address) shows `done_valid` in the cycle right after that edge. Each entry read adds exactly two cycles: the cycle in which `mem_req_valid` is high, and the cycle in which the bench holds the response. The bench samples at falling edges and counts them from the accept edge. It checks each read address in the cycle the request appears, and it requires the result to appear after exactly twice the number of expected reads, so a result that is early or late counts as a failure. One falling edge after the result, the bench also checks that `done_valid` has dropped and that `req_ready` has returned.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int XLEN       = 32;
    localparam int PG_SHIFT   = 12;
    localparam int IDX_W      = 10;
    localparam int PTE_BYTES  = 4;
    localparam int PPN_LSB    = 10;
    localparam int MAX_LEVELS = 2;

    localparam int PTE_W  = PTE_BYTES * 8;
    localparam int PTE_SH = $clog2(PTE_BYTES);
    localparam int PPN_W  = PTE_W - PPN_LSB;
    localparam int PA_W   = PPN_W + PG_SHIFT;
    localparam int VPN_W  = XLEN - PG_SHIFT;
    localparam int LVL_W  = $clog2(MAX_LEVELS + 1);

    // entry flag positions
    localparam int B_V = 0;
    localparam int B_R = 1;
    localparam int B_W = 2;
    localparam int B_X = 3;
    localparam int B_U = 4;
    localparam int B_A = 6;
    localparam int B_D = 7;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    localparam logic [1:0] PRIV_SUPER = 2'd1;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_FETCH_PF = 3'd1,
        FLT_LOAD_PF  = 3'd2,
        FLT_STORE_PF = 3'd3,
        FLT_ACCESS   = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_DONE
    } walk_state_e;

    typedef struct packed {
        logic [XLEN-1:0] vaddr;
        acc_e            acc;
        logic            supervisor;
        logic            sum;
        logic            mxr;
    } walk_req_t;

    function automatic fault_e page_fault_for(acc_e a);
        case (a)
            ACC_FETCH: return FLT_FETCH_PF;
            ACC_STORE: return FLT_STORE_PF;
            default:   return FLT_LOAD_PF;
        endcase
    endfunction

    function automatic logic is_pointer(logic [PTE_W-1:0] pte);
        return pte[B_V] && !pte[B_R] && !pte[B_W] && !pte[B_X];
    endfunction

    function automatic logic [PPN_W-1:0] low_mask(logic [LVL_W-1:0] lvl);
        logic [PPN_W-1:0] m;
        for (int i = 0; i < PPN_W; i++) begin
            m[i] = (i < int'(lvl) * IDX_W);
        end
        return m;
    endfunction

endpackage

// File: rtl/ptw_va_check.sv
module ptw_va_check
    import ptw_pkg::*;
(
    input  logic [XLEN-1:0]  vaddr,
    input  logic [LVL_W-1:0] levels,
    input  logic [LVL_W-1:0] cur_level,
    output logic             canonical,
    output logic [IDX_W-1:0] index
);
    localparam int NSEL = 1 << LVL_W;

    logic [NSEL-1:0] ok_per_level;

    assign ok_per_level[0] = 1'b1;

    generate
        for (genvar l = 1; l < NSEL; l++) begin : g_lvl
            if (l <= MAX_LEVELS) begin : g_valid
                localparam int TOP = PG_SHIFT + l * IDX_W - 1;
                logic [XLEN-1-TOP:0] upper;
                assign upper = vaddr[XLEN-1:TOP];
                assign ok_per_level[l] = (upper == '0) || (&upper);
            end else begin : g_over
                assign ok_per_level[l] = 1'b0;
            end
        end
    endgenerate

    assign canonical = ok_per_level[levels];
    assign index     = vaddr[PG_SHIFT + int'(cur_level) * IDX_W +: IDX_W];

endmodule

// File: rtl/ptw_leaf_check.sv
module ptw_leaf_check
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             eval,
    input  logic [PTE_W-1:0] pte,
    input  acc_e             acc,
    input  logic             supervisor,
    input  logic             sum,
    input  logic             mxr,
    input  logic [LVL_W-1:0] level,
    output logic             leaf_ok
);
    logic             v, r, w, x, u, a, d;
    logic [PPN_W-1:0] ppn;
    logic             priv_bad, enc_bad, perm_bad, align_bad, ad_bad;

    assign v   = pte[B_V];
    assign r   = pte[B_R];
    assign w   = pte[B_W];
    assign x   = pte[B_X];
    assign u   = pte[B_U];
    assign a   = pte[B_A];
    assign d   = pte[B_D];
    assign ppn = pte[PTE_W-1:PPN_LSB];

    assign priv_bad  = u ? (supervisor && !sum) : !supervisor;
    assign enc_bad   = !v || (w && !r);
    assign align_bad = |(ppn & low_mask(level));
    assign ad_bad    = !a || ((acc == ACC_STORE) && !d);

    always_comb begin
        case (acc)
            ACC_FETCH: perm_bad = !x;
            ACC_LOAD:  perm_bad = !(r || (mxr && x));
            ACC_STORE: perm_bad = !(r && w);
            default:   perm_bad = 1'b1;
        endcase
    end

    assign leaf_ok = !(priv_bad || enc_bad || perm_bad || align_bad || ad_bad);

    // R10: an accepted leaf always has A, and D too for a store
    assert_ad_present_R10: assert property (@(posedge clk) disable iff (rst)
        (eval && leaf_ok) |-> (pte[B_A] && (acc != ACC_STORE || pte[B_D])));

    // R9: an accepted superpage leaf is aligned
    assert_superpage_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        (eval && leaf_ok && level != '0) |-> (pte[PPN_LSB + IDX_W - 1:PPN_LSB] == '0));

    // R8: an accepted store has both read and write permission
    assert_store_rw_R8: assert property (@(posedge clk) disable iff (rst)
        (eval && leaf_ok && acc == ACC_STORE) |-> (pte[B_R] && pte[B_W]));

endmodule

// File: rtl/ptw_pa_build.sv
module ptw_pa_build
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic [XLEN-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  paddr
);
    logic [PPN_W-1:0] leaf_ppn;
    logic [PPN_W-1:0] vpn_ext;
    logic [PPN_W-1:0] merged;

    assign leaf_ppn = pte[PTE_W-1:PPN_LSB];
    assign vpn_ext  = PPN_W'(vaddr[XLEN-1:PG_SHIFT]);
    assign merged   = leaf_ppn | (vpn_ext & low_mask(level));
    assign paddr    = {merged, vaddr[PG_SHIFT-1:0]};

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [XLEN-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_priv,
    input  logic              req_sum,
    input  logic              req_mxr,
    input  logic [LVL_W-1:0]  cfg_levels,
    input  logic [PA_W-1:0]   cfg_root_base,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [PTE_W-1:0]  mem_resp_data,
    input  logic              mem_resp_err,
    output logic              done_valid,
    output logic [PA_W-1:0]   done_paddr,
    output logic [2:0]        done_fault
);
    walk_state_e      state_q;
    walk_req_t        req_q;
    logic [LVL_W-1:0] level_q;
    logic [PA_W-1:0]  base_q;
    logic [PA_W-1:0]  paddr_q;
    fault_e           fault_q;

    logic             idle;
    logic             accept;
    logic             resp_here;
    logic [XLEN-1:0]  chk_vaddr;
    logic             canonical;
    logic [IDX_W-1:0] index;
    logic             leaf_ok;
    logic [PA_W-1:0]  leaf_paddr;
    acc_e             in_acc;

    assign idle      = (state_q == S_IDLE);
    assign accept    = idle && req_valid;
    assign resp_here = (state_q == S_WAIT) && mem_resp_valid;
    assign chk_vaddr = idle ? req_vaddr : req_q.vaddr;
    assign in_acc    = acc_e'(req_acc);

    ptw_va_check u_va (
        .vaddr     (chk_vaddr),
        .levels    (cfg_levels),
        .cur_level (level_q),
        .canonical (canonical),
        .index     (index)
    );

    ptw_leaf_check u_leaf (
        .clk        (clk),
        .rst        (rst),
        .eval       (resp_here && !mem_resp_err && !is_pointer(mem_resp_data)),
        .pte        (mem_resp_data),
        .acc        (req_q.acc),
        .supervisor (req_q.supervisor),
        .sum        (req_q.sum),
        .mxr        (req_q.mxr),
        .level      (level_q),
        .leaf_ok    (leaf_ok)
    );

    ptw_pa_build u_pa (
        .pte   (mem_resp_data),
        .vaddr (req_q.vaddr),
        .level (level_q),
        .paddr (leaf_paddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            req_q   <= '0;
            level_q <= '0;
            base_q  <= '0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (accept) begin
                        req_q.vaddr      <= req_vaddr;
                        req_q.acc        <= in_acc;
                        req_q.supervisor <= (req_priv == PRIV_SUPER);
                        req_q.sum        <= req_sum;
                        req_q.mxr        <= req_mxr;
                        level_q          <= cfg_levels - 1'b1;
                        base_q           <= cfg_root_base;
                        if (cfg_levels == '0) begin
                            paddr_q <= PA_W'(req_vaddr);
                            fault_q <= FLT_NONE;
                            state_q <= S_DONE;
                        end else if (!canonical) begin
                            paddr_q <= '0;
                            fault_q <= page_fault_for(in_acc);
                            state_q <= S_DONE;
                        end else begin
                            state_q <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: state_q <= S_WAIT;
                S_WAIT: begin
                    if (mem_resp_valid) begin
                        if (mem_resp_err) begin
                            paddr_q <= '0;
                            fault_q <= FLT_ACCESS;
                            state_q <= S_DONE;
                        end else if (is_pointer(mem_resp_data)) begin
                            if (level_q == '0) begin
                                paddr_q <= '0;
                                fault_q <= page_fault_for(req_q.acc);
                                state_q <= S_DONE;
                            end else begin
                                base_q  <= {mem_resp_data[PTE_W-1:PPN_LSB], {PG_SHIFT{1'b0}}};
                                level_q <= level_q - 1'b1;
                                state_q <= S_ISSUE;
                            end
                        end else if (leaf_ok) begin
                            paddr_q <= leaf_paddr;
                            fault_q <= FLT_NONE;
                            state_q <= S_DONE;
                        end else begin
                            paddr_q <= '0;
                            fault_q <= page_fault_for(req_q.acc);
                            state_q <= S_DONE;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready     = idle;
    assign mem_req_valid = (state_q == S_ISSUE);
    assign mem_req_addr  = base_q + (PA_W'(index) << PTE_SH);
    assign done_valid    = (state_q == S_DONE);
    assign done_paddr    = paddr_q;
    assign done_fault    = fault_q;

    // R13: one read request per pulse
    assert_mem_req_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    // R13: result is a single-cycle pulse and the walker is then idle
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (!done_valid && req_ready));

    // R4: an error response turns into an access fault on the next cycle
    assert_err_to_access_R4: assert property (@(posedge clk) disable iff (rst)
        resp_here && mem_resp_err |=> (done_valid && done_fault == FLT_ACCESS));

    // R12: a faulting result carries a zero address
    assert_fault_zero_addr_R12: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault != FLT_NONE) |-> (done_paddr == '0));

endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
    import ptw_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_vaddr = '0;
    logic [1:0]        req_acc = '0;
    logic [1:0]        req_priv = '0;
    logic              req_sum = 1'b0;
    logic              req_mxr = 1'b0;
    logic [1:0]        cfg_levels = '0;
    logic [33:0]       cfg_root_base = '0;
    logic              mem_req_valid;
    logic [33:0]       mem_req_addr;
    logic              mem_resp_valid = 1'b0;
    logic [31:0]       mem_resp_data = '0;
    logic              mem_resp_err = 1'b0;
    logic              done_valid;
    logic [33:0]       done_paddr;
    logic [2:0]        done_fault;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    pt_walker dut_i (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_vaddr      (req_vaddr),
        .req_acc        (req_acc),
        .req_priv       (req_priv),
        .req_sum        (req_sum),
        .req_mxr        (req_mxr),
        .cfg_levels     (cfg_levels),
        .cfg_root_base  (cfg_root_base),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .mem_resp_err   (mem_resp_err),
        .done_valid     (done_valid),
        .done_paddr     (done_paddr),
        .done_fault     (done_fault)
    );

    typedef struct packed {
        logic [31:0] vaddr;
        logic [1:0]  acc;
        logic [1:0]  priv;
        logic        sum;
        logic        mxr;
        logic [1:0]  lv;
        logic [33:0] root;
        logic [31:0] pte_a;
        logic [31:0] pte_b;
        logic [2:0]  exp_fault;
        logic [33:0] exp_pa;
        logic [1:0]  exp_reads;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 22;
    localparam logic [33:0] RT = 34'h0_0001_0000;
    localparam logic [31:0] VA = 32'h0040_3abc;
    localparam logic [31:0] PT = 32'h0000_8001;

    localparam vec_t VECS [NV] = '{
        '{VA, 2'd1, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_14C7, 3'd0, 34'h0_0034_5abc, 2'd2, 8'd11}, // R11 R5 4K page
        '{VA, 2'd1, 2'd0, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_14C7, 3'd2, 34'h0, 2'd2, 8'd6},            // R6 user on S page
        '{VA, 2'd1, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_14D7, 3'd2, 34'h0, 2'd2, 8'd6},            // R6 U page, sum 0
        '{VA, 2'd1, 2'd1, 1'b1, 1'b0, 2'd2, RT, PT, 32'h000D_14D7, 3'd0, 34'h0_0034_5abc, 2'd2, 8'd6},  // R6 U page, sum 1
        '{VA, 2'd1, 2'd3, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_14C7, 3'd2, 34'h0, 2'd2, 8'd6},            // R6 machine mode
        '{VA, 2'd0, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_1443, 3'd1, 34'h0, 2'd2, 8'd8},            // R8 fetch no X
        '{VA, 2'd0, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_1449, 3'd0, 34'h0_0034_5abc, 2'd2, 8'd8},  // R8 fetch X
        '{VA, 2'd1, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_1449, 3'd2, 34'h0, 2'd2, 8'd8},            // R8 load X-only
        '{VA, 2'd1, 2'd1, 1'b0, 1'b1, 2'd2, RT, PT, 32'h000D_1449, 3'd0, 34'h0_0034_5abc, 2'd2, 8'd8},  // R8 load X-only mxr
        '{VA, 2'd2, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_14C3, 3'd3, 34'h0, 2'd2, 8'd8},            // R8 store no W
        '{VA, 2'd2, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_14C7, 3'd0, 34'h0_0034_5abc, 2'd2, 8'd8},  // R8 store RW
        '{VA, 2'd2, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_1447, 3'd3, 34'h0, 2'd2, 8'd10},           // R10 store no D
        '{VA, 2'd1, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_1403, 3'd2, 34'h0, 2'd2, 8'd10},           // R10 no A
        '{VA, 2'd2, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_14C5, 3'd3, 34'h0, 2'd2, 8'd7},            // R7 W without R
        '{VA, 2'd1, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, 32'h000D_1442, 3'd2, 34'h0, 2'd2, 8'd7},            // R7 V clear
        '{VA, 2'd1, 2'd1, 1'b0, 1'b0, 2'd2, RT, 32'h0010_00C7, 32'h0, 3'd0, 34'h0_0040_3abc, 2'd1, 8'd11}, // R11 superpage
        '{VA, 2'd1, 2'd1, 1'b0, 1'b0, 2'd2, RT, 32'h0010_04C7, 32'h0, 3'd2, 34'h0, 2'd1, 8'd9},         // R9 misaligned
        '{VA, 2'd0, 2'd1, 1'b0, 1'b0, 2'd2, RT, PT, PT, 3'd1, 34'h0, 2'd2, 8'd5},                       // R5 pointer at level 0
        '{32'hFFFF_F123, 2'd0, 2'd0, 1'b0, 1'b0, 2'd0, RT, 32'h0, 32'h0, 3'd0, 34'h0_FFFF_F123, 2'd0, 8'd1}, // R1 bare
        '{VA, 2'd2, 2'd1, 1'b0, 1'b0, 2'd1, RT, 32'h0, 32'h0, 3'd3, 34'h0, 2'd0, 8'd2},                 // R2 non-canonical
        '{32'h0010_3abc, 2'd1, 2'd1, 1'b0, 1'b0, 2'd1, RT, 32'h000D_14C7, 32'h0, 3'd0, 34'h0_0034_5abc, 2'd1, 8'd3}, // R3 one level
        '{VA, 2'd1, 2'd1, 1'b0, 1'b0, 2'd2, RT, 32'h8000_0001, 32'h0, 3'd4, 34'h0, 2'd2, 8'd4}          // R4 error on 2nd read
    };

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Memory legality: bit 33 of an entry address marks illegal memory (R4).
    task automatic run_vec(input vec_t v);
        logic [33:0] base;
        int          reads;
        int          waited;
        bit          got;
        base   = v.root;
        reads  = 0;
        waited = 0;
        got    = 1'b0;
        @(negedge clk);
        req_valid     = 1'b1;
        req_vaddr     = v.vaddr;
        req_acc       = v.acc;
        req_priv      = v.priv;
        req_sum       = v.sum;
        req_mxr       = v.mxr;
        cfg_levels    = v.lv;
        cfg_root_base = v.root;
        chk(req_ready == 1'b1, 13, "ready before request", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int step = 0; step < 20; step++) begin
            if (done_valid) begin
                got = 1'b1;
                break;
            end
            if (mem_req_valid) begin
                int          lvl;
                logic [33:0] exp_addr;
                logic [31:0] data;
                lvl      = int'(v.lv) - 1 - reads;
                exp_addr = base + (34'(v.vaddr[12 + 10 * lvl +: 10]) << 2);
                chk(mem_req_addr == exp_addr, 3, "entry address", 64'(mem_req_addr), 64'(exp_addr));
                chk(req_ready == 1'b0, 13, "ready while busy", 64'(req_ready), 64'd0);
                data = (reads == 0) ? v.pte_a : v.pte_b;
                @(negedge clk);
                waited++;
                chk(mem_req_valid == 1'b0, 13, "request pulse width", 64'(mem_req_valid), 64'd0);
                mem_resp_valid = 1'b1;
                mem_resp_data  = data;
                mem_resp_err   = exp_addr[33];
                base  = {data[31:10], 12'h000};
                reads++;
                @(negedge clk);
                waited++;
                mem_resp_valid = 1'b0;
                mem_resp_err   = 1'b0;
            end else begin
                @(negedge clk);
                waited++;
            end
        end
        chk(got, int'(v.rq), "result arrived", 64'(got), 64'd1);
        if (got) begin
            chk(done_fault == v.exp_fault, int'(v.rq), "fault code", 64'(done_fault), 64'(v.exp_fault));
            chk(done_paddr == v.exp_pa, int'(v.rq), "physical address", 64'(done_paddr), 64'(v.exp_pa));
            chk(reads == int'(v.exp_reads), int'(v.rq), "read count", 64'(reads), 64'(v.exp_reads));
            chk(waited == 2 * int'(v.exp_reads), 13, "result latency", 64'(waited), 64'(2 * v.exp_reads));
            @(negedge clk);
            chk(done_valid == 1'b0 && req_ready == 1'b1, 13, "done pulse then idle",
                64'({done_valid, req_ready}), 64'b01);
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) disable watchdog;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R14: reset state while reset is held
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && done_valid == 1'b0, 14,
            "state in reset", 64'({req_ready, mem_req_valid, done_valid}), 64'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && done_valid == 1'b0, 14, "idle after reset",
            64'({req_ready, done_valid}), 64'b10);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i]);
        end

        // R2: negative canonical address with one level walks normally
        run_vec('{32'hFFE0_1abc, 2'd1, 2'd1, 1'b0, 1'b0, 2'd1, RT, 32'h000D_14C7, 32'h0,
                  3'd0, 34'h0_0034_5abc, 2'd1, 8'd2});
        // R4: illegal root table address on the first read
        run_vec('{VA, 2'd0, 2'd1, 1'b0, 1'b0, 2'd2, 34'h2_0000_0000, 32'h0, 32'h0,
                  3'd4, 34'h0, 2'd1, 8'd4});

        // R14: reset in the middle of a walk returns to idle
        @(negedge clk);
        req_valid     = 1'b1;
        req_vaddr     = VA;
        req_acc       = 2'd1;
        req_priv      = 2'd1;
        cfg_levels    = 2'd2;
        cfg_root_base = RT;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && done_valid == 1'b0, 14,
            "idle after mid-walk reset", 64'({req_ready, mem_req_valid, done_valid}), 64'b100);
        @(negedge clk);
        chk(done_valid == 1'b0 && mem_req_valid == 1'b0, 14, "no stale activity",
            64'({done_valid, mem_req_valid}), 64'b00);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule